// File: doc/BRIEF.md
# Result Threshold Compare Monitor

This block watches the stream of conversion results that a converter front end produces, one result at a time, each tagged with the index of the sample slot that produced it. A set of comparator units each picks one slot, tests every result from that slot against its own 12-bit threshold, and counts how many qualifying results arrive in a row. When that run reaches a programmed length, the unit raises a sticky flag. Software clears the flag by writing 1 to it. An interrupt request is raised while any flag is set whose unit has its interrupt enabled.

Units are grouped in pairs: even unit 2k with odd unit 2k+1. Each pair has a window bit. While the window bit is set, a result counts for the even unit only if both units of the pair see a match on that same result. This lets two thresholds bound a band, for example "at or above the low limit and below the high limit". The odd unit keeps running on its own in every case. Each unit also exposes a live compare bit that shows whether the latest result from its slot was at or above its threshold.

The bus decoding around the block and the converter itself are outside it. Configuration arrives as plain input fields, and flag clears arrive as write-1 strobes.

Top module: `result_threshold_monitor`

## Requirements
- R1: After reset, every flag, every compare-output bit and the interrupt output are 0.
- R2: The condition bit of a unit picks its match test. At 0, a result matches when it is less than the threshold. At 1, it matches when it is greater than or equal to the threshold.
- R3: A unit acts only on results whose slot index equals its 5-bit slot selector. Results from any other slot change neither its flag nor its compare-output bit.
- R4: Each matching result from the selected slot adds one to the unit's match counter. The flag sets in the cycle after the result that brings the counter to the 4-bit count field. A count of 0 is treated as 1. The counter then restarts from zero.
- R5: A result from the selected slot that does not match resets that unit's match counter to zero.
- R6: When the window bit of pair k is 1, a result counts for unit 2k only if unit 2k+1 is enabled and its own test also matches that same result. Otherwise it counts as a non-match. Unit 2k+1 keeps its own independent flag. The window bit of pair k is bit k of the window field.
- R7: A 1 on a unit's clear strobe clears its flag in the next cycle. If the flag is set and cleared in the same cycle, the set wins.
- R8: The compare-output bit of a unit becomes 1 after a result from its slot that is at or above its threshold, and 0 after one that is below. The bit holds between such results.
- R9: While a unit's enable bit is 0, it ignores all results and its match counter is held at zero. Its flag is not set.
- R10: The interrupt output is 1 exactly when some unit has both its flag and its interrupt-enable bit at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| res_valid | input | 1 | A new result is present this cycle |
| res_slot | input | 5 | Sample slot index of the result |
| res_value | input | 12 | Result value, unsigned |
| cfg_en | input | 4 | Per-unit enable |
| cfg_irq_en | input | 4 | Per-unit interrupt enable |
| cfg_cond | input | 4 | Per-unit match test: 0 less-than, 1 at-or-above |
| cfg_slot | input | 20 | Per-unit slot selector, unit u in bits [5u+4:5u] |
| cfg_thresh | input | 48 | Per-unit threshold, unit u in bits [12u+11:12u] |
| cfg_count | input | 16 | Per-unit match count, unit u in bits [4u+3:4u] |
| cfg_window | input | 2 | Per-pair window enable, bit k for units 2k and 2k+1 |
| flag_clr | input | 4 | Per-unit write-1 clear strobe for the flag |
| flag | output | 4 | Per-unit sticky compare flag |
| cmp_out | output | 4 | Per-unit live compare bit |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with its default parameters: four units forming two pairs, 5-bit slot indices, 12-bit results and 4-bit match counts. With two pairs, the bench can exercise a window on pair 0 while units 2 and 3 check slot filtering and counter resets on their own. It uses slot 18 as a selector value and match counts of 0, 1, 2, 3 and 15. These values reach the count-of-zero rule, runs broken by a non-match, a counter restart after a flag, and the case where an odd unit flags by itself while its pair is in window mode.

// File: rtl/rtm_pkg.sv
// Package: shared helpers for the result threshold compare monitor.
// Assumes results and thresholds are unsigned values of equal width.
package rtm_pkg;

    // Match test selector values
    typedef enum logic {
        COND_BELOW   = 1'b0,
        COND_AT_ABOVE = 1'b1
    } rtm_cond_e;

    // Pick the match outcome from the at-or-above comparison
    function automatic logic rtm_is_match(input logic cond, input logic at_or_above);
        return (cond == COND_AT_ABOVE) ? at_or_above : !at_or_above;
    endfunction

endpackage

// File: rtl/rtm_compare.sv
// Module: combinational threshold test for one unit.
// Gives the at-or-above result and the match outcome under the unit's
// condition bit. Assumes the value and threshold are unsigned.
module rtm_compare
    import rtm_pkg::*;
#(
    parameter int RES_W = 12
) (
    input  logic [RES_W-1:0] value,
    input  logic [RES_W-1:0] thresh,
    input  logic             cond,
    output logic             at_or_above,
    output logic             match
);

    // Magnitude test and condition selection
    always_comb begin
        at_or_above = (value >= thresh);
        match       = rtm_is_match(cond, at_or_above);
    end

endmodule

// File: rtl/rtm_unit.sv
// Module: match counter, sticky flag and live compare bit for one unit.
// hit marks a result from the unit's slot while the unit is enabled;
// qual says whether that result counts as a match (window already applied).
// Assumes hit is 0 whenever en is 0.
module rtm_unit #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             hit,
    input  logic             qual,
    input  logic             at_or_above,
    input  logic [CNT_W-1:0] count_cfg,
    input  logic             clr,
    output logic             flag,
    output logic             cmp_out
);

    localparam int EXT_W = CNT_W + 1;

    logic [CNT_W-1:0] cnt;
    logic [EXT_W-1:0] target;
    logic [EXT_W-1:0] next_cnt;
    logic             reach;

    // Effective target (0 means 1) and reach test for the next match
    always_comb begin
        target   = (count_cfg == '0) ? EXT_W'(1) : {1'b0, count_cfg};
        next_cnt = {1'b0, cnt} + EXT_W'(1);
        reach    = (next_cnt >= target);
    end

    // Match counter: count matches, reset on non-match, disable or reach
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            cnt <= '0;
        end else if (hit) begin
            if (!qual || reach) cnt <= '0;
            else                cnt <= next_cnt[CNT_W-1:0];
        end
    end

    // Sticky flag: set on reach wins over a same-cycle clear
    always_ff @(posedge clk) begin
        if (!rst_n)                     flag <= 1'b0;
        else if (hit && qual && reach)  flag <= 1'b1;
        else if (clr)                   flag <= 1'b0;
    end

    // Live compare bit follows each result from the selected slot
    always_ff @(posedge clk) begin
        if (!rst_n)   cmp_out <= 1'b0;
        else if (hit) cmp_out <= at_or_above;
    end

    // R5: a non-matching result empties the counter
    assert_nomatch_resets_R5: assert property (@(posedge clk) disable iff (!rst_n)
        hit && !qual |=> cnt == '0);

    // R9: a disabled unit holds its counter at zero
    assert_disabled_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> cnt == '0);

    // R4: the flag only rises after a qualifying result
    assert_flag_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag) |-> $past(hit && qual));

    // R7: a clear with no result drops the flag
    assert_clear_drops_R7: assert property (@(posedge clk) disable iff (!rst_n)
        clr && !hit |=> !flag);

    // R8: compare bit reflects the last selected result
    assert_cmp_tracks_R8: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> cmp_out == $past(at_or_above));

endmodule

// File: rtl/result_threshold_monitor.sv
// Module: top of the result threshold compare monitor.
// Each unit watches one sample slot; even/odd unit pairs can form a
// window. Assumes res_slot is only meaningful while res_valid is 1.
module result_threshold_monitor #(
    parameter int NUM_UNITS = 4,
    parameter int RES_W     = 12,
    parameter int SLOT_W    = 5,
    parameter int CNT_W     = 4,
    localparam int NUM_PAIRS = NUM_UNITS / 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       res_valid,
    input  logic [SLOT_W-1:0]          res_slot,
    input  logic [RES_W-1:0]           res_value,
    input  logic [NUM_UNITS-1:0]       cfg_en,
    input  logic [NUM_UNITS-1:0]       cfg_irq_en,
    input  logic [NUM_UNITS-1:0]       cfg_cond,
    input  logic [NUM_UNITS*SLOT_W-1:0] cfg_slot,
    input  logic [NUM_UNITS*RES_W-1:0] cfg_thresh,
    input  logic [NUM_UNITS*CNT_W-1:0] cfg_count,
    input  logic [NUM_PAIRS-1:0]       cfg_window,
    input  logic [NUM_UNITS-1:0]       flag_clr,
    output logic [NUM_UNITS-1:0]       flag,
    output logic [NUM_UNITS-1:0]       cmp_out,
    output logic                       irq
);

    logic [NUM_UNITS-1:0] ge;
    logic [NUM_UNITS-1:0] match;
    logic [NUM_UNITS-1:0] hit;
    logic [NUM_UNITS-1:0] qual;

    for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
        rtm_compare #(.RES_W(RES_W)) u_cmp (
            .value       (res_value),
            .thresh      (cfg_thresh[u*RES_W +: RES_W]),
            .cond        (cfg_cond[u]),
            .at_or_above (ge[u]),
            .match       (match[u])
        );

        // Slot selection gated by enable
        always_comb begin
            hit[u] = res_valid && cfg_en[u] && (res_slot == cfg_slot[u*SLOT_W +: SLOT_W]);
        end

        if ((u % 2 == 0) && (u + 1 < NUM_UNITS)) begin : g_win
            // Even unit: in window mode the partner must match the same result
            always_comb begin
                qual[u] = match[u] &&
                          (!cfg_window[u/2] || (match[u+1] && cfg_en[u+1]));
            end
        end else begin : g_solo
            // Odd or unpaired unit: own match only
            always_comb begin
                qual[u] = match[u];
            end
        end

        rtm_unit #(.CNT_W(CNT_W)) u_unit (
            .clk         (clk),
            .rst_n       (rst_n),
            .en          (cfg_en[u]),
            .hit         (hit[u]),
            .qual        (qual[u]),
            .at_or_above (ge[u]),
            .count_cfg   (cfg_count[u*CNT_W +: CNT_W]),
            .clr         (flag_clr[u]),
            .flag        (flag[u]),
            .cmp_out     (cmp_out[u])
        );
    end

    // Interrupt request from enabled flags
    always_comb begin
        irq = |(flag & cfg_irq_en);
    end

    // R10: an unmasked flag is seen as an interrupt request
    assert_irq_follows_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ((flag & cfg_irq_en) != '0) |-> irq);

    // R1: first cycle out of reset shows no flags
    assert_reset_clear_R1: assert property (@(posedge clk)
        $past(!rst_n) |-> (flag == '0 && cmp_out == '0));

endmodule

// File: tb/result_threshold_monitor_tb.sv
module result_threshold_monitor_tb;

    localparam int NU = 4;
    localparam int RW = 12;
    localparam int SW = 5;
    localparam int CW = 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              res_valid = 1'b0;
    logic [SW-1:0]     res_slot = '0;
    logic [RW-1:0]     res_value = '0;
    logic [NU-1:0]     cfg_en = '0;
    logic [NU-1:0]     cfg_irq_en = '0;
    logic [NU-1:0]     cfg_cond = '0;
    logic [NU*SW-1:0]  cfg_slot = '0;
    logic [NU*RW-1:0]  cfg_thresh = '0;
    logic [NU*CW-1:0]  cfg_count = '0;
    logic [NU/2-1:0]   cfg_window = '0;
    logic [NU-1:0]     flag_clr = '0;
    logic [NU-1:0]     flag;
    logic [NU-1:0]     cmp_out;
    logic              irq;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    result_threshold_monitor u_dut (
        .clk(clk), .rst_n(rst_n), .res_valid(res_valid), .res_slot(res_slot),
        .res_value(res_value), .cfg_en(cfg_en), .cfg_irq_en(cfg_irq_en),
        .cfg_cond(cfg_cond), .cfg_slot(cfg_slot), .cfg_thresh(cfg_thresh),
        .cfg_count(cfg_count), .cfg_window(cfg_window), .flag_clr(flag_clr),
        .flag(flag), .cmp_out(cmp_out), .irq(irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic set_unit(input int u, input logic en, input logic ie, input logic cond,
                            input logic [SW-1:0] slot, input logic [RW-1:0] thr,
                            input logic [CW-1:0] cnt);
        cfg_en[u]               = en;
        cfg_irq_en[u]           = ie;
        cfg_cond[u]             = cond;
        cfg_slot[u*SW +: SW]    = slot;
        cfg_thresh[u*RW +: RW]  = thr;
        cfg_count[u*CW +: CW]   = cnt;
    endtask

    // One result for one cycle; outputs are read at the negedge after
    task automatic send(input logic [SW-1:0] s, input logic [RW-1:0] v, input logic [NU-1:0] clr);
        @(negedge clk);
        res_valid = 1'b1; res_slot = s; res_value = v; flag_clr = clr;
        @(negedge clk);
        res_valid = 1'b0; flag_clr = '0;
    endtask

    task automatic pulse_clr(input logic [NU-1:0] clr);
        @(negedge clk);
        flag_clr = clr;
        @(negedge clk);
        flag_clr = '0;
    endtask

    task automatic idle_all();
        @(negedge clk);
        cfg_en = '0; cfg_irq_en = '0; cfg_window = '0;
        pulse_clr('1);
    endtask

    task automatic t_reset();
        check("R1 flag", flag, 0);
        check("R1 cmp_out", cmp_out, 0);
        check("R1 irq", irq, 0);
    endtask

    task automatic t_below();
        idle_all();
        set_unit(0, 1, 0, 0, 3, 12'h800, 2);
        send(3, 12'h100, 0);
        check("R2/R4 below first", flag[0], 0);
        check("R8 below cmp", cmp_out[0], 0);
        send(3, 12'h7FF, 0);
        check("R2/R4 below second flags", flag[0], 1);
        send(3, 12'h800, 0);
        check("R8 at threshold cmp", cmp_out[0], 1);
    endtask

    task automatic t_at_above();
        idle_all();
        set_unit(1, 1, 0, 1, 5, 12'h400, 0);
        send(5, 12'h3FF, 0);
        check("R2 ge no match", flag[1], 0);
        check("R8 cmp low", cmp_out[1], 0);
        send(5, 12'h400, 0);
        check("R4 count0 as 1 flags", flag[1], 1);
        check("R8 cmp high", cmp_out[1], 1);
    endtask

    task automatic t_slot();
        idle_all();
        set_unit(2, 1, 0, 1, 18, 12'h000, 1);
        send(17, 12'hFFF, 0);
        check("R3 other slot flag", flag[2], 0);
        check("R3 other slot cmp", cmp_out[2], 0);
        send(18, 12'h005, 0);
        check("R3 slot 18 flags", flag[2], 1);
    endtask

    task automatic t_run();
        idle_all();
        set_unit(3, 1, 0, 1, 7, 12'h100, 3);
        send(7, 12'h200, 0);
        send(7, 12'h200, 0);
        send(7, 12'h050, 0);
        send(7, 12'h200, 0);
        send(7, 12'h200, 0);
        check("R5 broken run no flag", flag[3], 0);
        send(7, 12'h200, 0);
        check("R5 third after reset flags", flag[3], 1);
        pulse_clr(4'b1000);
        send(7, 12'h200, 0);
        send(7, 12'h200, 0);
        check("R4 counter restarted", flag[3], 0);
        send(7, 12'h200, 0);
        check("R4 restart reaches again", flag[3], 1);
    endtask

    task automatic t_window();
        idle_all();
        set_unit(0, 1, 0, 1, 2, 12'h300, 1);
        set_unit(1, 1, 0, 0, 2, 12'h600, 15);
        cfg_window = 2'b01;
        send(2, 12'h200, 0);
        check("R6 low fails", flag[0], 0);
        send(2, 12'h700, 0);
        check("R6 partner fails", flag[0], 0);
        send(2, 12'h400, 0);
        check("R6 both match", flag[0], 1);
        check("R6 odd unit count15 idle", flag[1], 0);
        pulse_clr(4'b0011);
        set_unit(1, 1, 0, 0, 2, 12'h600, 1);
        send(2, 12'h100, 0);
        check("R6 odd flags alone", flag[1], 1);
        check("R6 even stays clear", flag[0], 0);
        pulse_clr(4'b0011);
        cfg_en[1] = 1'b0;
        send(2, 12'h400, 0);
        check("R6 disabled partner blocks", flag[0], 0);
    endtask

    task automatic t_clear();
        idle_all();
        set_unit(0, 1, 0, 1, 1, 12'h000, 1);
        send(1, 12'h001, 0);
        check("R7 set", flag[0], 1);
        pulse_clr(4'b0001);
        check("R7 cleared", flag[0], 0);
        send(1, 12'h001, 4'b0001);
        check("R7 set wins", flag[0], 1);
    endtask

    task automatic t_enable();
        idle_all();
        set_unit(0, 0, 0, 1, 4, 12'h000, 2);
        send(4, 12'h010, 0);
        send(4, 12'h010, 0);
        check("R9 disabled no flag", flag[0], 0);
        cfg_en[0] = 1'b1;
        send(4, 12'h010, 0);
        check("R9 counter was held", flag[0], 0);
        send(4, 12'h010, 0);
        check("R9 enabled flags", flag[0], 1);
    endtask

    task automatic t_irq();
        idle_all();
        set_unit(2, 1, 0, 1, 9, 12'h000, 1);
        send(9, 12'h001, 0);
        check("R10 masked", irq, 0);
        @(negedge clk);
        cfg_irq_en[2] = 1'b1;
        #1;
        check("R10 unmasked", irq, 1);
        pulse_clr(4'b0100);
        check("R10 cleared", irq, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_below();
        t_at_above();
        t_slot();
        t_run();
        t_window();
        t_clear();
        t_enable();
        t_irq();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule